// File: doc/BRIEF.md
# Instruction Prefix and Escape Scanner

This block is the front of a variable-length instruction decoder. Instruction bytes arrive one per cycle on a valid/ready stream. Each byte in the legacy prefix classes is absorbed into a per-instruction context: operand-size flip, address-size flip, repeat qualifier and segment override. Prefixes may come in any order and may repeat. The first byte outside those classes ends the prefix run. If that byte is the two-byte escape, one more byte is taken as the opcode, and it is looked up in the secondary opcode space.

Once the opcode byte is taken, the block presents one registered header. The header gives the effective operand and address sizes, the repeat kind, the segment selector and a flag saying whether an override set it, the escape flag, the opcode byte, the number of bytes consumed, and whether a ModRM byte follows. The header is held until the downstream stage accepts it. The default sizes come from two mode inputs. An instruction that would run past the length limit is dropped and signalled on a one-cycle error output.

Top module: `instr_prefix_scanner`

## Requirements
- R1: After reset, hdrValid and errFlag are 0 and byteReady is 1.
- R2: A 0x66 byte sets the operand size to the size that is not the mode default (hdrOpSize32 = !modeOp32). Further 0x66 bytes in the same instruction leave it flipped.
- R3: A 0x67 byte flips the address size the same way (hdrAddrSize32 = !modeAddr32), and repeats of it leave it flipped.
- R4: hdrRep encodes the repeat kind: 0 = none, 1 = 0xF2 (repeat while not equal), 2 = 0xF3 (repeat while equal). The last repeat prefix in the instruction wins.
- R5: The segment override bytes 0x26, 0x2E, 0x36 and 0x3E set hdrSegOverride to 1 and hdrSegSel to 0, 1, 2 and 3 (ES, CS, SS, DS). The last override wins. With no override, hdrSegOverride is 0 and hdrSegSel is 3 (DS).
- R6: When 0x0F is the first non-prefix byte, hdrEscape is 1 and the next byte becomes hdrOpcode, whatever its value. Otherwise hdrEscape is 0 and hdrOpcode is the first non-prefix byte.
- R7: hdrLen equals the count of all bytes consumed: prefixes, escape and opcode.
- R8: hdrNeedsModrm is 1 for primary opcodes 0x00–0x3F with bit 2 clear, and for 0x62, 0x63, 0x69, 0x6B, 0x80–0x8F, 0xC0, 0xC1, 0xC4–0xC7, 0xD0–0xD3, 0xF6, 0xF7, 0xFE and 0xFF. It is also 1 for secondary opcodes 0x40–0x4F, 0x90–0x9F, 0xA3–0xA5, 0xAB–0xAD, 0xAF, 0xB2, 0xB4 and 0xB5. It is 0 for every other opcode.
- R9: While hdrValid is 1, byteReady is 0, no byte is consumed, and every header field stays stable until a cycle with hdrReady 1.
- R10: If a prefix or escape byte is consumed as byte number MaxLen, errFlag pulses for exactly one cycle and no header is produced. The next byte starts a fresh instruction with no context carried over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeOp32 | input | 1 | Default operand size is 32 when 1, 16 when 0 |
| modeAddr32 | input | 1 | Default address size is 32 when 1, 16 when 0 |
| byteValid | input | 1 | Instruction byte present |
| byteData | input | 8 | Instruction byte |
| byteReady | output | 1 | Block accepts a byte this cycle |
| hdrValid | output | 1 | Header present |
| hdrReady | input | 1 | Downstream accepts the header |
| hdrOpSize32 | output | 1 | Effective operand size is 32 |
| hdrAddrSize32 | output | 1 | Effective address size is 32 |
| hdrRep | output | 2 | Repeat kind (0 none, 1 not-equal, 2 equal) |
| hdrSegOverride | output | 1 | Segment came from an override prefix |
| hdrSegSel | output | 2 | Segment (0 ES, 1 CS, 2 SS, 3 DS) |
| hdrEscape | output | 1 | Opcode is from the secondary space |
| hdrOpcode | output | 8 | Opcode byte |
| hdrLen | output | LenW (4) | Bytes consumed for this instruction |
| hdrNeedsModrm | output | 1 | A ModRM byte follows the opcode |
| errFlag | output | 1 | One-cycle pulse: instruction exceeded the length limit |

## Verification
The bench builds the block with the default MaxLen of 15. That value is small enough to reach the limit with real prefix runs: fourteen prefixes plus an opcode make a legal 15-byte instruction, and fifteen prefixes, or an escape in the fifteenth slot, trip the error. The bench runs both mode inputs at both values, so the size flips are seen against 16-bit and 32-bit defaults. It also offers a byte while a header is held, to show that the byte waits and is not lost.

// File: rtl/pfx_scan_pkg.sv
package pfx_scan_pkg;

  typedef enum logic [1:0] {
    REP_NONE = 2'd0,
    REP_NE   = 2'd1,
    REP_E    = 2'd2
  } repKind_t;

  typedef enum logic [2:0] {
    CL_OPCODE = 3'd0,
    CL_OPSZ   = 3'd1,
    CL_ADSZ   = 3'd2,
    CL_REP    = 3'd3,
    CL_SEG    = 3'd4,
    CL_ESC    = 3'd5
  } byteClass_t;

  typedef struct packed {
    logic clear;
    logic takePrefix;
    logic takeEscape;
    logic takeOpcode;
    logic hold;
  } strobe_t;

  localparam logic [1:0] SEG_DS = 2'd3;

endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class
  import pfx_scan_pkg::*;
(
  input  logic [7:0]  byteData,
  input  logic        escMode,
  output byteClass_t  cls,
  output logic        needsModrm
);

  function automatic logic primaryModrm(input logic [7:0] b);
    logic r;
    r = 1'b0;
    if (b[7:6] == 2'b00 && !b[2]) r = 1'b1;
    if (b[7:4] == 4'h8) r = 1'b1;
    if (b[7:2] == 6'b110100) r = 1'b1;
    if (b[7:2] == 6'b110001) r = 1'b1;
    case (b)
      8'h62, 8'h63, 8'h69, 8'h6B,
      8'hC0, 8'hC1, 8'hF6, 8'hF7, 8'hFE, 8'hFF: r = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic secondaryModrm(input logic [7:0] b);
    logic r;
    r = (b[7:4] == 4'h4) || (b[7:4] == 4'h9);
    case (b)
      8'hA3, 8'hA4, 8'hA5, 8'hAB, 8'hAC, 8'hAD, 8'hAF,
      8'hB2, 8'hB4, 8'hB5: r = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

  always_comb begin
    cls = CL_OPCODE;
    if (!escMode) begin
      case (byteData)
        8'h66: cls = CL_OPSZ;
        8'h67: cls = CL_ADSZ;
        8'hF2, 8'hF3: cls = CL_REP;
        8'h26, 8'h2E, 8'h36, 8'h3E: cls = CL_SEG;
        8'h0F: cls = CL_ESC;
        default: cls = CL_OPCODE;
      endcase
    end
  end

  assign needsModrm = escMode ? secondaryModrm(byteData) : primaryModrm(byteData);

endmodule

// File: rtl/pfx_scan_ctrl.sv
module pfx_scan_ctrl
  import pfx_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        hdrReady,
  input  byteClass_t  cls,
  input  logic        atLastSlot,
  output logic        byteReady,
  output logic        hdrValid,
  output logic        escMode,
  output logic        errFlag,
  output strobe_t     strb
);

  typedef enum logic [1:0] {ST_SCAN, ST_ESC, ST_HOLD} state_t;

  state_t stateQ, stateD;
  logic   errNow;
  logic   accept;

  assign byteReady = (stateQ != ST_HOLD);
  assign hdrValid  = (stateQ == ST_HOLD);
  assign escMode   = (stateQ == ST_ESC);
  assign accept    = byteValid && byteReady;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    errNow = 1'b0;
    unique case (stateQ)
      ST_SCAN: if (accept) begin
        if (cls == CL_OPCODE) begin
          strb.takeOpcode = 1'b1;
          stateD = ST_HOLD;
        end else if (atLastSlot) begin
          errNow     = 1'b1;
          strb.clear = 1'b1;
        end else if (cls == CL_ESC) begin
          strb.takeEscape = 1'b1;
          stateD = ST_ESC;
        end else begin
          strb.takePrefix = 1'b1;
        end
      end
      ST_ESC: if (accept) begin
        strb.takeOpcode = 1'b1;
        stateD = ST_HOLD;
      end
      ST_HOLD: begin
        strb.hold = 1'b1;
        if (hdrReady) begin
          strb.clear = 1'b1;
          stateD = ST_SCAN;
        end
      end
      default: stateD = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_SCAN;
      errFlag <= 1'b0;
    end else begin
      stateQ  <= stateD;
      errFlag <= errNow;
    end
  end

  assert_no_accept_while_holding_R9: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> !byteReady);

  assert_err_single_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !errFlag);

  assert_err_without_header_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !hdrValid);

endmodule

// File: rtl/pfx_scan_dp.sv
module pfx_scan_dp
  import pfx_scan_pkg::*;
#(
  parameter int MaxLen = 15,
  parameter int LenW   = $clog2(MaxLen + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      byteData,
  input  logic            modeOp32,
  input  logic            modeAddr32,
  input  strobe_t         strb,
  input  byteClass_t      cls,
  input  logic            needsModrm,
  output logic            atLastSlot,
  output logic            hdrOpSize32,
  output logic            hdrAddrSize32,
  output logic [1:0]      hdrRep,
  output logic            hdrSegOverride,
  output logic [1:0]      hdrSegSel,
  output logic            hdrEscape,
  output logic [7:0]      hdrOpcode,
  output logic [LenW-1:0] hdrLen,
  output logic            hdrNeedsModrm
);

  localparam logic [LenW-1:0] LastSlot = LenW'(MaxLen - 1);
  localparam logic [LenW-1:0] LenOne   = LenW'(1);

  logic [LenW-1:0] lenQ;
  logic            opFlipQ, adFlipQ;
  repKind_t        repQ;
  logic            segOvrQ;
  logic [1:0]      segQ;
  logic            escQ;
  logic [7:0]      opcodeQ;
  logic            modrmQ, op32Q, ad32Q;

  assign atLastSlot = (lenQ == LastSlot);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      lenQ    <= '0;
      opFlipQ <= 1'b0;
      adFlipQ <= 1'b0;
      repQ    <= REP_NONE;
      segOvrQ <= 1'b0;
      segQ    <= SEG_DS;
      escQ    <= 1'b0;
      opcodeQ <= '0;
      modrmQ  <= 1'b0;
      op32Q   <= 1'b0;
      ad32Q   <= 1'b0;
    end else begin
      if (strb.takePrefix) begin
        lenQ <= lenQ + LenOne;
        case (cls)
          CL_OPSZ: opFlipQ <= 1'b1;
          CL_ADSZ: adFlipQ <= 1'b1;
          CL_REP:  repQ    <= byteData[0] ? REP_E : REP_NE;
          CL_SEG: begin
            segOvrQ <= 1'b1;
            segQ    <= byteData[4:3];
          end
          default: ;
        endcase
      end
      if (strb.takeEscape) begin
        lenQ <= lenQ + LenOne;
        escQ <= 1'b1;
      end
      if (strb.takeOpcode) begin
        lenQ    <= lenQ + LenOne;
        opcodeQ <= byteData;
        modrmQ  <= needsModrm;
        op32Q   <= modeOp32 ^ opFlipQ;
        ad32Q   <= modeAddr32 ^ adFlipQ;
      end
    end
  end

  assign hdrOpSize32    = op32Q;
  assign hdrAddrSize32  = ad32Q;
  assign hdrRep         = repQ;
  assign hdrSegOverride = segOvrQ;
  assign hdrSegSel      = segQ;
  assign hdrEscape      = escQ;
  assign hdrOpcode      = opcodeQ;
  assign hdrLen         = lenQ;
  assign hdrNeedsModrm  = modrmQ;

  assert_len_in_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    lenQ <= LenW'(MaxLen));

  assert_rep_code_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    repQ != 2'b11);

  assert_header_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hold && !strb.clear) |=> ($stable(opcodeQ) && $stable(lenQ) && $stable(segQ)
                                    && $stable(repQ) && $stable(op32Q)));

  assert_default_seg_ds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !segOvrQ |-> segQ == SEG_DS);

endmodule

// File: rtl/instr_prefix_scanner.sv
module instr_prefix_scanner
  import pfx_scan_pkg::*;
#(
  parameter int MaxLen = 15,
  parameter int LenW   = $clog2(MaxLen + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeOp32,
  input  logic            modeAddr32,
  input  logic            byteValid,
  input  logic [7:0]      byteData,
  output logic            byteReady,
  output logic            hdrValid,
  input  logic            hdrReady,
  output logic            hdrOpSize32,
  output logic            hdrAddrSize32,
  output logic [1:0]      hdrRep,
  output logic            hdrSegOverride,
  output logic [1:0]      hdrSegSel,
  output logic            hdrEscape,
  output logic [7:0]      hdrOpcode,
  output logic [LenW-1:0] hdrLen,
  output logic            hdrNeedsModrm,
  output logic            errFlag
);

  byteClass_t cls;
  logic       needsModrm;
  logic       escMode;
  logic       atLastSlot;
  strobe_t    strb;

  pfx_byte_class class_i (
    .byteData   (byteData),
    .escMode    (escMode),
    .cls        (cls),
    .needsModrm (needsModrm)
  );

  pfx_scan_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .hdrReady   (hdrReady),
    .cls        (cls),
    .atLastSlot (atLastSlot),
    .byteReady  (byteReady),
    .hdrValid   (hdrValid),
    .escMode    (escMode),
    .errFlag    (errFlag),
    .strb       (strb)
  );

  pfx_scan_dp #(.MaxLen(MaxLen), .LenW(LenW)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .byteData       (byteData),
    .modeOp32       (modeOp32),
    .modeAddr32     (modeAddr32),
    .strb           (strb),
    .cls            (cls),
    .needsModrm     (needsModrm),
    .atLastSlot     (atLastSlot),
    .hdrOpSize32    (hdrOpSize32),
    .hdrAddrSize32  (hdrAddrSize32),
    .hdrRep         (hdrRep),
    .hdrSegOverride (hdrSegOverride),
    .hdrSegSel      (hdrSegSel),
    .hdrEscape      (hdrEscape),
    .hdrOpcode      (hdrOpcode),
    .hdrLen         (hdrLen),
    .hdrNeedsModrm  (hdrNeedsModrm)
  );

endmodule

// File: tb/instr_prefix_scanner_tb_top.sv
module instr_prefix_scanner_tb_top;

  localparam int ClkPeriod = 10;
  localparam int NumVec    = 12;

  typedef struct packed {
    logic [2:0]  n;
    logic [39:0] bytes;
    logic        mOp;
    logic        mAd;
    logic        eOp32;
    logic        eAd32;
    logic [1:0]  eRep;
    logic        eOvr;
    logic [1:0]  eSeg;
    logic        eEsc;
    logic [7:0]  eOpc;
    logic [3:0]  eLen;
    logic        eModrm;
  } vec_t;

  localparam vec_t Vecs [NumVec] = '{
    '{3'd1, 40'h9000000000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3, 1'b0, 8'h90, 4'd1, 1'b0},
    '{3'd2, 40'h6601000000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd3, 1'b0, 8'h01, 4'd2, 1'b1},
    '{3'd3, 40'h6667890000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3, 1'b0, 8'h89, 4'd3, 1'b1},
    '{3'd2, 40'hF3A4000000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 2'd3, 1'b0, 8'hA4, 4'd2, 1'b0},
    '{3'd3, 40'hF3F2A40000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 2'd3, 1'b0, 8'hA4, 4'd3, 1'b0},
    '{3'd2, 40'h2E8B000000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 8'h8B, 4'd2, 1'b1},
    '{3'd3, 40'h26368B0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 8'h8B, 4'd3, 1'b1},
    '{3'd2, 40'h0F84000000, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 2'd3, 1'b1, 8'h84, 4'd2, 1'b0},
    '{3'd2, 40'h0FAF000000, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd3, 1'b1, 8'hAF, 4'd2, 1'b1},
    '{3'd4, 40'h6666670500, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 2'd3, 1'b0, 8'h05, 4'd4, 1'b0},
    '{3'd3, 40'h3E0F940000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3, 1'b1, 8'h94, 4'd3, 1'b1},
    '{3'd3, 40'h670F660000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd3, 1'b1, 8'h66, 4'd3, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeOp32 = 1'b0, modeAddr32 = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       hdrReady = 1'b0;
  logic       byteReady, hdrValid, hdrOpSize32, hdrAddrSize32;
  logic [1:0] hdrRep, hdrSegSel;
  logic       hdrSegOverride, hdrEscape, hdrNeedsModrm, errFlag;
  logic [7:0] hdrOpcode;
  logic [3:0] hdrLen;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(ClkPeriod / 2) clk = ~clk;

  instr_prefix_scanner dut_i (
    .clk(clk), .rstN(rstN), .modeOp32(modeOp32), .modeAddr32(modeAddr32),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .hdrValid(hdrValid), .hdrReady(hdrReady), .hdrOpSize32(hdrOpSize32),
    .hdrAddrSize32(hdrAddrSize32), .hdrRep(hdrRep), .hdrSegOverride(hdrSegOverride),
    .hdrSegSel(hdrSegSel), .hdrEscape(hdrEscape), .hdrOpcode(hdrOpcode),
    .hdrLen(hdrLen), .hdrNeedsModrm(hdrNeedsModrm), .errFlag(errFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    byteValid = 1'b1;
    byteData  = b;
    @(posedge clk);
    #1;
    byteValid = 1'b0;
  endtask

  task automatic release_hdr();
    @(negedge clk);
    hdrReady = 1'b1;
    @(posedge clk);
    #1;
    hdrReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 hdrValid", hdrValid, 0);
    chk("R1 byteReady", byteReady, 1);
    chk("R1 errFlag", errFlag, 0);

    for (int v = 0; v < NumVec; v++) begin
      modeOp32   = Vecs[v].mOp;
      modeAddr32 = Vecs[v].mAd;
      @(negedge clk);
      for (int k = 0; k < int'(Vecs[v].n); k++)
        sendByte(Vecs[v].bytes[39 - 8*k -: 8]);
      @(negedge clk);
      chk("R9 hdrValid", hdrValid, 1);
      chk("R2 opsize", hdrOpSize32, Vecs[v].eOp32);
      chk("R3 addrsize", hdrAddrSize32, Vecs[v].eAd32);
      chk("R4 rep", hdrRep, Vecs[v].eRep);
      chk("R5 override", hdrSegOverride, Vecs[v].eOvr);
      chk("R5 segsel", hdrSegSel, Vecs[v].eSeg);
      chk("R6 escape", hdrEscape, Vecs[v].eEsc);
      chk("R6 opcode", hdrOpcode, Vecs[v].eOpc);
      chk("R7 len", hdrLen, Vecs[v].eLen);
      chk("R8 modrm", hdrNeedsModrm, Vecs[v].eModrm);
      release_hdr();
    end

    // R9: header held, an offered byte waits
    modeOp32 = 1'b0; modeAddr32 = 1'b0;
    @(negedge clk);
    sendByte(8'h90);
    byteValid = 1'b1;
    byteData  = 8'h01;
    repeat (3) @(negedge clk);
    chk("R9 byteReady low while held", byteReady, 0);
    chk("R9 opcode stable", hdrOpcode, 8'h90);
    chk("R9 len stable", hdrLen, 1);
    hdrReady = 1'b1;
    @(posedge clk);
    #1 hdrReady = 1'b0;
    @(posedge clk);
    #1 byteValid = 1'b0;
    @(negedge clk);
    chk("R9 waiting byte taken", hdrOpcode, 8'h01);
    chk("R9 waiting byte len", hdrLen, 1);
    release_hdr();

    // R7: 14 prefixes + opcode = 15 bytes, legal
    @(negedge clk);
    for (int k = 0; k < 14; k++) sendByte(8'h2E);
    sendByte(8'h90);
    @(negedge clk);
    chk("R7 max length header", hdrValid, 1);
    chk("R7 max length count", hdrLen, 15);
    chk("R5 override on long", hdrSegSel, 1);
    release_hdr();

    // R10: 15 prefixes trips the limit
    @(negedge clk);
    for (int k = 0; k < 15; k++) sendByte(8'h2E);
    @(negedge clk);
    chk("R10 errFlag pulse", errFlag, 1);
    chk("R10 no header", hdrValid, 0);
    @(negedge clk);
    chk("R10 errFlag one cycle", errFlag, 0);
    sendByte(8'h90);
    @(negedge clk);
    chk("R10 fresh override", hdrSegOverride, 0);
    chk("R10 fresh segsel", hdrSegSel, 3);
    chk("R10 fresh len", hdrLen, 1);
    release_hdr();

    // R10: escape in last slot trips the limit
    @(negedge clk);
    for (int k = 0; k < 14; k++) sendByte(8'h66);
    sendByte(8'h0F);
    @(negedge clk);
    chk("R10 escape at limit", errFlag, 1);
    chk("R10 escape no header", hdrValid, 0);
    sendByte(8'h05);
    @(negedge clk);
    chk("R10 fresh opsize", hdrOpSize32, 0);
    chk("R10 fresh escape", hdrEscape, 0);
    chk("R10 fresh opcode", hdrOpcode, 8'h05);
    release_hdr();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule